// File: doc/BRIEF.md
# Padded Key Mixing Unit

This block prepares a binary key for a later encoding stage by folding it with a swapped copy of itself. The key is cut into an upper (left) half and a lower (right) half. When a half holds an odd number of bits it is stretched by one bit: a zero goes under the left half and a one goes under the right half. The stretched halves are joined with the left one on top. A dummy key is built from the same two halves in swapped order, stretched by the same rule. The mixed key is the bitwise XOR of the joined key and the dummy key.

The key width is a parameter and must be even. Its half length may be odd, and in that case the mixed key is two bits wider than the input. A key is offered on a valid/ready input. One clock later the registered result appears with a valid flag and the effective width of the mixed key.

Top module: `keymix_top`

## Requirements
- R1: While `rst` is high at a rising clock edge, `out_valid` is 0 after that edge. After reset no output is valid until a key has been accepted.
- R2: `in_ready` is 0 while `rst` is high and 1 otherwise. A key is accepted at a rising edge where `in_valid` and `in_ready` are both 1.
- R3: `out_valid` is 1 in exactly the cycle after each accepted key and 0 after any edge with no acceptance. Keys accepted on consecutive edges produce results on consecutive cycles.
- R4: With half length H = KEY_W/2, left half L = key[KEY_W-1:H] and right half R = key[H-1:0], the output is computed as follows. For odd H it is {L,0,R,1} XOR {R,0,L,1}. For even H it is {L,R} XOR {R,L}.
- R5: For odd H the stretch bits follow the rule: a 0 under the left half and a 1 under the right half, in both the joined key and the dummy key. Output bits H+1 and 0 are therefore 0.
- R6: `out_width` equals KEY_W+2 when H is odd and KEY_W when H is even. With the default KEY_W=18 this is 20.
- R7: After an edge with no accepted key, `out_key` and `out_width` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Key offered |
| in_ready | output | 1 | Block can accept a key |
| in_key | input | KEY_W | Input key |
| out_valid | output | 1 | Mixed key valid this cycle |
| out_key | output | 2*(H+H%2) | Mixed key |
| out_width | output | clog2(OUT_W+1) | Effective width of the mixed key |

## Verification
The hardest behaviour to show at the ports is the stretch bits. In both the joined key and the dummy key they sit in the same positions, so a correct design always returns zeros there. The stimulus drives halves with all ones, alternating bits and equal halves, and checks that the two stretch positions stay 0 while the folded halves change around them. A reset raised while a key is being offered, and keys offered on consecutive edges, cover the valid timing.

// File: rtl/keymix_pkg.sv
package keymix_pkg;

    localparam logic PAD_LEFT  = 1'b0;
    localparam logic PAD_RIGHT = 1'b1;

    typedef enum logic {
        WIDTH_KEEP = 1'b0,
        WIDTH_GROW = 1'b1
    } width_case_e;

    function automatic int half_len(input int key_w);
        return key_w / 2;
    endfunction

    function automatic int padded_len(input int h);
        return h + (h % 2);
    endfunction

    function automatic width_case_e width_case(input int key_w);
        return ((key_w / 2) % 2 == 1) ? WIDTH_GROW : WIDTH_KEEP;
    endfunction

    function automatic int mixed_len(input int key_w);
        return 2 * padded_len(key_w / 2);
    endfunction

    function automatic int width_bits(input int key_w);
        return $clog2(mixed_len(key_w) + 1);
    endfunction

endpackage

// File: rtl/keymix_halfpad.sv
module keymix_halfpad #(
    parameter int   HALF_W  = 9,
    parameter logic PAD_BIT = 1'b0,
    localparam int  PAD_W   = keymix_pkg::padded_len(HALF_W)
) (
    input  logic [HALF_W-1:0] half_in,
    output logic [PAD_W-1:0]  half_out
);

    generate
        if (HALF_W % 2 == 1) begin : g_odd
            assign half_out = {half_in, PAD_BIT};
        end else begin : g_even
            assign half_out = half_in;
        end
    endgenerate

endmodule

// File: rtl/keymix_combine.sv
module keymix_combine #(
    parameter int  KEY_W = 18,
    localparam int H     = keymix_pkg::half_len(KEY_W),
    localparam int HP    = keymix_pkg::padded_len(H),
    localparam int OW    = 2 * HP
) (
    input  logic [KEY_W-1:0] key_in,
    output logic [OW-1:0]    mixed
);
    import keymix_pkg::*;

    logic [H-1:0]  left_h, right_h;
    logic [HP-1:0] join_hi, join_lo, dum_hi, dum_lo;
    logic [OW-1:0] joined, dummy;

    assign left_h  = key_in[KEY_W-1:H];
    assign right_h = key_in[H-1:0];

    keymix_halfpad #(.HALF_W(H), .PAD_BIT(PAD_LEFT)) u_join_hi (
        .half_in(left_h), .half_out(join_hi));
    keymix_halfpad #(.HALF_W(H), .PAD_BIT(PAD_RIGHT)) u_join_lo (
        .half_in(right_h), .half_out(join_lo));
    keymix_halfpad #(.HALF_W(H), .PAD_BIT(PAD_LEFT)) u_dum_hi (
        .half_in(right_h), .half_out(dum_hi));
    keymix_halfpad #(.HALF_W(H), .PAD_BIT(PAD_RIGHT)) u_dum_lo (
        .half_in(left_h), .half_out(dum_lo));

    assign joined = {join_hi, join_lo};
    assign dummy  = {dum_hi, dum_lo};
    assign mixed  = joined ^ dummy;

endmodule

// File: rtl/keymix_outreg.sv
module keymix_outreg #(
    parameter int DATA_W  = 20,
    parameter int WIDTH_W = 5
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic [DATA_W-1:0]  data_in,
    input  logic [WIDTH_W-1:0] width_in,
    output logic               valid_q,
    output logic [DATA_W-1:0]  data_q,
    output logic [WIDTH_W-1:0] width_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
        end else begin
            valid_q <= load;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q  <= '0;
            width_q <= '0;
        end else if (load) begin
            data_q  <= data_in;
            width_q <= width_in;
        end
    end

endmodule

// File: rtl/keymix_top.sv
module keymix_top #(
    parameter int  KEY_W = 18,
    localparam int OW    = keymix_pkg::mixed_len(KEY_W),
    localparam int WW    = keymix_pkg::width_bits(KEY_W)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [KEY_W-1:0] in_key,
    output logic          out_valid,
    output logic [OW-1:0] out_key,
    output logic [WW-1:0] out_width
);
    import keymix_pkg::*;

    localparam width_case_e WCASE = width_case(KEY_W);
    localparam int EFF_W = (WCASE == WIDTH_GROW) ? KEY_W + 2 : KEY_W;

    logic          accept;
    logic [OW-1:0] mixed;
    logic [WW-1:0] eff_width;

    initial begin
        if (KEY_W % 2 != 0 || KEY_W < 2) begin
            $error("KEY_W must be even and at least 2");
        end
    end

    assign in_ready  = ~rst;
    assign accept    = in_valid & in_ready;
    assign eff_width = WW'(EFF_W);

    keymix_combine #(.KEY_W(KEY_W)) u_combine (
        .key_in(in_key),
        .mixed (mixed)
    );

    keymix_outreg #(.DATA_W(OW), .WIDTH_W(WW)) u_outreg (
        .clk     (clk),
        .rst     (rst),
        .load    (accept),
        .data_in (mixed),
        .width_in(eff_width),
        .valid_q (out_valid),
        .data_q  (out_key),
        .width_q (out_width)
    );

endmodule

// File: rtl/keymix_chk.sv
module keymix_chk #(
    parameter int  KEY_W = 18,
    localparam int H     = keymix_pkg::half_len(KEY_W),
    localparam int HP    = keymix_pkg::padded_len(H),
    localparam int OW    = 2 * HP,
    localparam int WW    = keymix_pkg::width_bits(KEY_W)
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic             in_ready,
    input logic [KEY_W-1:0] in_key,
    input logic             out_valid,
    input logic [OW-1:0]    out_key,
    input logic [WW-1:0]    out_width
);

    localparam int EXP_W = (H % 2 == 1) ? KEY_W + 2 : KEY_W;

    logic acc;
    assign acc = in_valid && in_ready;

    assert_reset_clears_R1: assert property (@(posedge clk)
        rst |=> !out_valid);

    assert_valid_follows_R3: assert property (@(posedge clk) disable iff (rst)
        acc |=> out_valid);

    assert_no_spurious_R3: assert property (@(posedge clk) disable iff (rst)
        !acc |=> !out_valid);

    assert_fold_data_R4: assert property (@(posedge clk) disable iff (rst)
        acc |=> out_key[OW-1 -: H] == $past(in_key[KEY_W-1:H] ^ in_key[H-1:0]));

    assert_halves_mirror_R4: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> out_key[OW-1:HP] == out_key[HP-1:0]);

    assert_pad_zero_R5: assert property (@(posedge clk) disable iff (rst)
        out_valid && (H % 2 == 1) |-> !out_key[HP] && !out_key[0]);

    assert_width_R6: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> out_width == WW'(EXP_W));

    assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !acc |=> $stable(out_key) && $stable(out_width));

endmodule

bind keymix_top keymix_chk #(.KEY_W(KEY_W)) u_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_key(in_key), .out_valid(out_valid), .out_key(out_key),
    .out_width(out_width)
);

// File: tb/sim_keymix_top.sv
module sim_keymix_top;

    localparam int KW = 18;
    localparam int H  = 9;
    localparam int OW = 20;
    localparam int WW = 5;
    localparam int NV = 8;

    localparam logic [KW-1:0] VEC [NV] = '{
        18'h00000, 18'h3FFFF, 18'h3FE00, 18'h001FF,
        18'h2AAAA, 18'h15555, 18'h12345, 18'h0F0F3
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic in_ready;
    logic [KW-1:0] in_key = '0;
    logic out_valid;
    logic [OW-1:0] out_key;
    logic [WW-1:0] out_width;

    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;

    keymix_top #(.KEY_W(KW)) u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_key(in_key), .out_valid(out_valid), .out_key(out_key),
        .out_width(out_width)
    );

    function automatic logic [OW-1:0] model(input logic [KW-1:0] k);
        logic [H-1:0] l, r;
        logic [OW-1:0] pk, dk;
        l  = k[KW-1:H];
        r  = k[H-1:0];
        pk = {l, 1'b0, r, 1'b1};
        dk = {r, 1'b0, l, 1'b1};
        return pk ^ dk;
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic offer_and_check(input logic [KW-1:0] k);
        logic [OW-1:0] held;
        in_key   = k;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R3 valid after accept", 64'(out_valid), 64'd1);
        chk("R4 mixed key", 64'(out_key), 64'(model(k)));
        chk("R5 pad bits", 64'({out_key[H+1], out_key[0]}), 64'd0);
        chk("R6 width", 64'(out_width), 64'd20);
        held = out_key;
        in_key = ~k;
        @(negedge clk);
        chk("R3 valid drops", 64'(out_valid), 64'd0);
        chk("R7 key held", 64'(out_key), 64'(held));
        chk("R7 width held", 64'(out_width), 64'd20);
    endtask

    initial begin
        #4_000_000;
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        @(negedge clk);
        in_valid = 1'b1;
        @(negedge clk);
        chk("R1 valid in reset", 64'(out_valid), 64'd0);
        chk("R2 ready in reset", 64'(in_ready), 64'd0);
        in_valid = 1'b0;
        rst = 1'b0;
        @(negedge clk);
        chk("R2 ready after reset", 64'(in_ready), 64'd1);
        chk("R1 no output before accept", 64'(out_valid), 64'd0);

        for (int i = 0; i < NV; i++) begin
            offer_and_check(VEC[i]);
        end

        // R3 back-to-back acceptance
        in_key = 18'h2B3C1;
        in_valid = 1'b1;
        @(negedge clk);
        chk("R3 first of pair", 64'(out_valid), 64'd1);
        chk("R4 first of pair", 64'(out_key), 64'(model(18'h2B3C1)));
        in_key = 18'h1C0F7;
        @(negedge clk);
        chk("R3 second of pair", 64'(out_valid), 64'd1);
        chk("R4 second of pair", 64'(out_key), 64'(model(18'h1C0F7)));

        // R1 reset while a key is being offered
        rst = 1'b1;
        @(negedge clk);
        chk("R1 reset mid stream", 64'(out_valid), 64'd0);
        chk("R2 ready drops in reset", 64'(in_ready), 64'd0);
        in_valid = 1'b0;
        rst = 1'b0;
        @(negedge clk);
        chk("R1 idle after reset", 64'(out_valid), 64'd0);
        offer_and_check(18'h3C5A6);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule